// File: doc/BRIEF.md
# Transmit Jabber and Heartbeat Supervisor

This block watches the transmit side of a 10 Mb/s twisted-pair attachment unit. It times every transmission, and when one runs too long it shuts the line driver off and holds it off until the transmitter has been silent for a long continuous stretch. While that lockout lasts it signals collision to the controller and pulls an active-low jabber status low. After each normal frame it sends a short heartbeat pulse on the collision line, so the controller can confirm that the collision path works. It also raises collision when transmit and receive overlap in half-duplex operation.

All signals inside the block are active high except the two status outputs, which are active low so they can drive indicator lamps. Every duration is counted in cycles of the 20 MHz clock. The jabber limit and the quiet time are parameters; their defaults are 50 ms and 500 ms. The heartbeat delay and the heartbeat width are 20 cycles each, which is 1 µs. Link pulses are generated elsewhere and are not gated here.

Top module: `tx_supervisor`

## Requirements
- R1: After reset, jabber is latched on the clock edge that samples transmit enable high for the JAB_LIMIT_CYC-th consecutive time. From that edge on, `jab_n_o` is 0.
- R2: While jabber is latched, `tx_out_en_o` is 0 and `col_o` is 1. While jabber is not latched, `tx_out_en_o` equals `tx_en_i`. Collision rises on the same edge that latches jabber.
- R3: Latched jabber clears on the edge that samples `tx_en_i` low for the JAB_QUIET_CYC-th consecutive time. Any sample of `tx_en_i` high restarts that count.
- R4: A high sample of `jab_dis_i` clears any latched jabber and the duration count. While it is high, jabber is never latched.
- R5: A transmission that drops before reaching the limit resets the duration count, so frames of JAB_LIMIT_CYC-1 cycles never latch jabber.
- R6: Let E0 be the first edge that samples `tx_en_i` low after a high sample. If jabber is not latched and the link is not failed at E0, `col_o` is high for exactly SQE_WIDTH_CYC cycles, starting on edge E0+SQE_DELAY_CYC.
- R7: The heartbeat is not started, or is abandoned on the next edge, when jabber is latched, when `link_fail_i` is high, or when `tx_en_i` is sampled high again.
- R8: With full duplex and loopback both low, an edge that samples `tx_en_i` and `rx_active_i` both high drives `col_o` to 1 and `col_led_n_o` to 0 for the following cycle.
- R9: While `full_dup_i` or `loopback_i` is high, an overlap of transmit and receive raises neither collision nor the collision lamp.
- R10: `col_led_n_o` is low during jabber and during real collisions, and stays high during the heartbeat pulse. `col_o` is high in all three cases.
- R11: During reset, `jab_n_o` and `col_led_n_o` are 1 and `col_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 20 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable from the controller |
| rx_active_i | input | 1 | Receive path carries valid data |
| link_fail_i | input | 1 | Link integrity is in the fail state |
| jab_dis_i | input | 1 | Turns jabber detection off |
| full_dup_i | input | 1 | Full-duplex operation |
| loopback_i | input | 1 | Local loopback operation |
| tx_out_en_o | output | 1 | Enable for the line driver |
| col_o | output | 1 | Collision to the controller |
| jab_n_o | output | 1 | Jabber status, low while latched |
| col_led_n_o | output | 1 | Collision lamp, low during jabber or real collision |

## Verification
The hardest case to reach is the exit from jabber. A frame must first stay up for the whole limit, and then a long quiet run must follow. Interrupting that run with even one transmit cycle must restart it. The timer settings are shortened for the bench so that a directed test can cover this in a reasonable number of cycles. That test runs a frame of exactly the limit and one cycle short of it. It then breaks the quiet run with a one-cycle blip and counts the edges to the release. The random phase uses frame lengths that straddle the limit and gaps that are sometimes shorter than the heartbeat window. This makes heartbeat aborts, and heartbeats suppressed by jabber, happen many times.

// File: rtl/txsup_pkg.sv
package txsup_pkg;

    // Phases of the post-frame heartbeat sequencer
    typedef enum logic [1:0] {
        SQE_IDLE = 2'd0,
        SQE_WAIT = 2'd1,
        SQE_FIRE = 2'd2
    } sqe_phase_e;

endpackage

// File: rtl/txsup_jabber.sv
module txsup_jabber #(
    parameter int unsigned LIMIT_CYC = 1_000_000,
    parameter int unsigned QUIET_CYC = 10_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tx_en_i,
    input  logic jab_dis_i,
    output logic jab_o
);

    localparam int unsigned RW = (LIMIT_CYC > 2) ? $clog2(LIMIT_CYC) : 1;
    localparam int unsigned QW = (QUIET_CYC > 2) ? $clog2(QUIET_CYC) : 1;
    localparam logic [RW-1:0] RUN_LAST   = RW'(LIMIT_CYC - 1);
    localparam logic [QW-1:0] QUIET_LAST = QW'(QUIET_CYC - 1);

    typedef struct packed {
        logic          jab;
        logic [RW-1:0] run;
        logic [QW-1:0] quiet;
    } jab_state_t;

    jab_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (jab_dis_i) begin
            state_d.jab   = 1'b0;
            state_d.run   = '0;
            state_d.quiet = '0;
        end else if (!state_q.jab) begin
            state_d.quiet = '0;
            if (tx_en_i) begin
                if (state_q.run == RUN_LAST) begin
                    state_d.jab = 1'b1;
                    state_d.run = '0;
                end else begin
                    state_d.run = state_q.run + 1'b1;
                end
            end else begin
                state_d.run = '0;
            end
        end else begin
            state_d.run = '0;
            if (tx_en_i) begin
                state_d.quiet = '0;
            end else if (state_q.quiet == QUIET_LAST) begin
                state_d.jab   = 1'b0;
                state_d.quiet = '0;
            end else begin
                state_d.quiet = state_q.quiet + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign jab_o = state_q.jab;

endmodule

// File: rtl/txsup_sqe.sv
module txsup_sqe
    import txsup_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 20,
    parameter int unsigned WIDTH_CYC = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tx_en_i,
    input  logic jab_i,
    input  logic link_fail_i,
    output logic pulse_o
);

    localparam int unsigned MAXC = (DELAY_CYC > WIDTH_CYC) ? DELAY_CYC : WIDTH_CYC;
    localparam int unsigned CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] WAIT_LAST = CW'(DELAY_CYC - 1);
    localparam logic [CW-1:0] FIRE_LAST = CW'(WIDTH_CYC - 1);

    typedef struct packed {
        sqe_phase_e    phase;
        logic          en_prev;
        logic [CW-1:0] cnt;
    } sqe_state_t;

    sqe_state_t state_d, state_q;
    logic       abort;

    assign abort = tx_en_i | jab_i | link_fail_i;

    always_comb begin
        state_d         = state_q;
        state_d.en_prev = tx_en_i;
        unique case (state_q.phase)
            SQE_IDLE: begin
                if (state_q.en_prev && !abort) begin
                    state_d.phase = SQE_WAIT;
                    state_d.cnt   = '0;
                end
            end
            SQE_WAIT: begin
                if (abort) begin
                    state_d.phase = SQE_IDLE;
                end else if (state_q.cnt == WAIT_LAST) begin
                    state_d.phase = SQE_FIRE;
                    state_d.cnt   = '0;
                end else begin
                    state_d.cnt = state_q.cnt + 1'b1;
                end
            end
            SQE_FIRE: begin
                if (abort || state_q.cnt == FIRE_LAST) begin
                    state_d.phase = SQE_IDLE;
                    state_d.cnt   = '0;
                end else begin
                    state_d.cnt = state_q.cnt + 1'b1;
                end
            end
            default: state_d.phase = SQE_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '{phase: SQE_IDLE, en_prev: 1'b0, cnt: '0};
        else         state_q <= state_d;
    end

    assign pulse_o = (state_q.phase == SQE_FIRE);

endmodule

// File: rtl/tx_supervisor.sv
module tx_supervisor #(
    parameter int unsigned JAB_LIMIT_CYC = 1_000_000,
    parameter int unsigned JAB_QUIET_CYC = 10_000_000,
    parameter int unsigned SQE_DELAY_CYC = 20,
    parameter int unsigned SQE_WIDTH_CYC = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tx_en_i,
    input  logic rx_active_i,
    input  logic link_fail_i,
    input  logic jab_dis_i,
    input  logic full_dup_i,
    input  logic loopback_i,
    output logic tx_out_en_o,
    output logic col_o,
    output logic jab_n_o,
    output logic col_led_n_o
);

    typedef struct packed {
        logic coll;
    } top_state_t;

    top_state_t state_d, state_q;
    logic       jab;
    logic       sqe_pulse;

    txsup_jabber #(
        .LIMIT_CYC (JAB_LIMIT_CYC),
        .QUIET_CYC (JAB_QUIET_CYC)
    ) i_jabber (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tx_en_i   (tx_en_i),
        .jab_dis_i (jab_dis_i),
        .jab_o     (jab)
    );

    txsup_sqe #(
        .DELAY_CYC (SQE_DELAY_CYC),
        .WIDTH_CYC (SQE_WIDTH_CYC)
    ) i_sqe (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tx_en_i     (tx_en_i),
        .jab_i       (jab),
        .link_fail_i (link_fail_i),
        .pulse_o     (sqe_pulse)
    );

    always_comb begin
        state_d      = state_q;
        state_d.coll = tx_en_i & rx_active_i & ~full_dup_i & ~loopback_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign tx_out_en_o = tx_en_i & ~jab;
    assign col_o       = jab | state_q.coll | sqe_pulse;
    assign jab_n_o     = ~jab;
    assign col_led_n_o = ~(jab | state_q.coll);

endmodule

// File: rtl/txsup_chk.sv
module txsup_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic tx_en_i,
    input logic rx_active_i,
    input logic link_fail_i,
    input logic jab_dis_i,
    input logic full_dup_i,
    input logic loopback_i,
    input logic tx_out_en_o,
    input logic col_o,
    input logic jab_n_o,
    input logic col_led_n_o
);

    // R1
    jab_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(jab_n_o) |-> $past(tx_en_i));

    // R2
    jab_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !jab_n_o |-> (!tx_out_en_o && col_o));

    // R3
    jab_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(jab_n_o) |-> (!$past(tx_en_i) || $past(jab_dis_i)));

    // R4
    jab_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(jab_dis_i) |-> jab_n_o);

    // R8
    real_coll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(tx_en_i && rx_active_i && !full_dup_i && !loopback_i)
            |-> (col_o && !col_led_n_o));

    // R10
    led_implies_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !col_led_n_o |-> col_o);

    // R11
    always_comb begin
        if (!rst_ni) begin
            reset_state_chk: assert (jab_n_o && col_led_n_o && !col_o);
        end
    end

endmodule

bind tx_supervisor txsup_chk i_chk (.*);

// File: tb/test_tx_supervisor.sv
module test_tx_supervisor;

    localparam int LIM = 300;
    localparam int QT  = 600;
    localparam int DLY = 20;
    localparam int WID = 20;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic tx_en = 0, rx_active = 0, link_fail = 0, jab_dis = 0, full_dup = 0, loopback = 0;
    logic tx_out_en, col, jab_n, col_led_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tx_supervisor #(
        .JAB_LIMIT_CYC (LIM),
        .JAB_QUIET_CYC (QT),
        .SQE_DELAY_CYC (DLY),
        .SQE_WIDTH_CYC (WID)
    ) i_tx_supervisor (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .tx_en_i     (tx_en),
        .rx_active_i (rx_active),
        .link_fail_i (link_fail),
        .jab_dis_i   (jab_dis),
        .full_dup_i  (full_dup),
        .loopback_i  (loopback),
        .tx_out_en_o (tx_out_en),
        .col_o       (col),
        .jab_n_o     (jab_n),
        .col_led_n_o (col_led_n)
    );

    // Reference state
    logic m_jab = 0, m_coll = 0, m_prev = 0, m_arm = 0;
    int   m_hi = 0, m_lo = 0, m_since = 0;

    always @(posedge clk) begin
        logic ojab;
        if (!rst_ni) begin
            m_jab = 0; m_coll = 0; m_prev = 0; m_arm = 0;
            m_hi = 0; m_lo = 0; m_since = 0;
        end else begin
            ojab = m_jab;
            if (m_arm) begin
                if (tx_en || ojab || link_fail) m_arm = 0;
                else begin
                    m_since++;
                    if (m_since == DLY + WID) m_arm = 0;
                end
            end else if (m_prev && !tx_en && !ojab && !link_fail) begin
                m_arm = 1; m_since = 0;
            end
            if (jab_dis) begin
                m_jab = 0; m_hi = 0; m_lo = 0;
            end else if (!m_jab) begin
                m_lo = 0;
                if (tx_en) begin
                    m_hi++;
                    if (m_hi == LIM) begin m_jab = 1; m_hi = 0; end
                end else m_hi = 0;
            end else begin
                m_hi = 0;
                if (tx_en) m_lo = 0;
                else begin
                    m_lo++;
                    if (m_lo == QT) begin m_jab = 0; m_lo = 0; end
                end
            end
            m_coll = tx_en & rx_active & ~full_dup & ~loopback;
            m_prev = tx_en;
        end
    end

    function automatic logic exp_col();
        return m_jab | m_coll | (m_arm && m_since >= DLY);
    endfunction
    function automatic logic exp_led_n();
        return ~(m_jab | m_coll);
    endfunction
    function automatic logic exp_txo();
        return tx_en & ~m_jab;
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison, 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (rst_ni) begin
            chk("R1", "jab_n", jab_n, ~m_jab);
            chk("R2", "tx_out_en", tx_out_en, exp_txo());
            chk("R6", "col", col, exp_col());
            chk("R10", "col_led_n", col_led_n, exp_led_n());
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        idle(3);
        chk("R11", "reset jab_n", jab_n, 1'b1);
        chk("R11", "reset col", col, 1'b0);
        chk("R11", "reset col_led_n", col_led_n, 1'b1);
        rst_ni = 1'b1;
        idle(5);

        // R5: frames one cycle short of the limit never latch
        for (int k = 0; k < 2; k++) begin
            tx_en = 1; idle(LIM - 1);
            tx_en = 0; idle(60);
            chk("R5", "short frame jab_n", jab_n, 1'b1);
        end

        // R6: heartbeat timing and width, lamp stays off (R10)
        tx_en = 1; idle(10);
        tx_en = 0; idle(DLY);
        chk("R6", "col before heartbeat", col, 1'b0);
        idle(1);
        chk("R6", "col heartbeat start", col, 1'b1);
        chk("R10", "lamp off during heartbeat", col_led_n, 1'b1);
        idle(WID - 1);
        chk("R6", "col heartbeat last", col, 1'b1);
        idle(1);
        chk("R6", "col heartbeat end", col, 1'b0);
        idle(10);

        // R1 and R2: exact limit latches jabber
        tx_en = 1; idle(LIM - 1);
        chk("R1", "jab_n one short", jab_n, 1'b1);
        chk("R2", "tx_out_en before limit", tx_out_en, 1'b1);
        idle(1);
        chk("R1", "jab_n at limit", jab_n, 1'b0);
        chk("R2", "tx_out_en gated", tx_out_en, 1'b0);
        chk("R2", "col with jabber", col, 1'b1);
        chk("R10", "lamp on with jabber", col_led_n, 1'b0);
        idle(20);

        // R3: quiet run broken by a blip, then full quiet run
        tx_en = 0; idle(100);
        tx_en = 1; idle(1);
        chk("R2", "blip gated", tx_out_en, 1'b0);
        tx_en = 0; idle(QT - 1);
        chk("R3", "jab_n before quiet end", jab_n, 1'b0);
        idle(1);
        chk("R3", "jab_n released", jab_n, 1'b1);
        chk("R7", "no heartbeat after jabber", col, 1'b0);
        idle(DLY + WID + 5);
        chk("R7", "still no heartbeat", col, 1'b0);

        // R7: link fail suppresses heartbeat
        link_fail = 1;
        tx_en = 1; idle(8);
        tx_en = 0; idle(DLY + 1);
        chk("R7", "link fail heartbeat", col, 1'b0);
        idle(WID);
        link_fail = 0;

        // R7: new frame inside the delay aborts heartbeat
        tx_en = 1; idle(8);
        tx_en = 0; idle(5);
        tx_en = 1; idle(3);
        tx_en = 0; idle(DLY);
        chk("R7", "restart delay col", col, 1'b0);
        idle(WID + 5);

        // R8 and R9: real collision and its masking
        tx_en = 1; rx_active = 1; idle(1);
        chk("R8", "real col", col, 1'b1);
        chk("R8", "real col lamp", col_led_n, 1'b0);
        full_dup = 1; idle(2);
        chk("R9", "full duplex col", col, 1'b0);
        full_dup = 0; loopback = 1; idle(2);
        chk("R9", "loopback lamp", col_led_n, 1'b1);
        loopback = 0; rx_active = 0; tx_en = 0; idle(DLY + WID + 5);

        // R4: jabber disabled
        jab_dis = 1;
        tx_en = 1; idle(LIM + 50);
        chk("R4", "jab_dis jab_n", jab_n, 1'b1);
        chk("R4", "jab_dis tx_out_en", tx_out_en, 1'b1);
        tx_en = 0; jab_dis = 0; idle(DLY + WID + 5);

        // Random phase
        for (int f = 0; f < 110; f++) begin
            int len, gap;
            link_fail = ($urandom_range(0, 7) == 0);
            full_dup  = ($urandom_range(0, 7) == 0);
            loopback  = ($urandom_range(0, 7) == 0);
            jab_dis   = ($urandom_range(0, 9) == 0);
            len = $urandom_range(1, LIM + 60);
            gap = $urandom_range(0, 3) == 0 ? $urandom_range(0, 40) : $urandom_range(0, 700);
            tx_en = 1;
            for (int c = 0; c < len; c++) begin
                if ($urandom_range(0, 15) == 0) rx_active = ~rx_active;
                @(negedge clk);
            end
            tx_en = 0;
            for (int c = 0; c < gap; c++) begin
                if ($urandom_range(0, 15) == 0) rx_active = ~rx_active;
                if ($urandom_range(0, 63) == 0) link_fail = ~link_fail;
                @(negedge clk);
            end
        end
        idle(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule